// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog timer that a host programs through a small byte-addressed register file of 16-bit words. A 10-bit counter decrements once for each cycle in which the `tick` input is high and counting is not halted. The nominal tick period is 0.6 s, and the tick is generated outside the block. Software keeps the system alive by writing the reload code before the counter runs out. When the counter does run out, the block first only raises a status flag and starts a new period. If the counter runs out again while that flag is still set, the block sets a second flag and asks for a system reset. A no-reboot control bit can suppress that reset request.

A small state machine sequences the block. Its states are HALTED (counting disabled), COUNTING (the counter runs) and FIRING (a single cycle that drives the reset request). The transitions are:
- HALTED goes to COUNTING when the halt bit clears.
- COUNTING goes to HALTED when the halt bit sets.
- Any state goes to FIRING on a second expiry that reboot is allowed to follow.
- FIRING returns to COUNTING or HALTED, depending on the halt bit.

Top module: `dual_expiry_wdt`

## Requirements
- R1: After reset the block is in this state: counting halted, initial value 4, count 4, all status flags clear, no-reboot set and `rst_req` low. Reading offset 0x08 returns 0x0801.
- R2: Control word 0x08 holds the halt bit at bit 11 and the no-reboot bit at bit 0. While halt is 1 the count holds. While halt is 0 the count falls by one in each cycle with `tick` high.
- R3: Writing exactly 0x0001 to offset 0x00 loads the count from the initial value. A write of any other value there is ignored. A reload in the same cycle as a tick takes priority, and no expiry happens in that cycle.
- R4: A read of offset 0x00 returns the live count in bits [9:0], with bits [15:10] zero. Unmapped offsets read as zero.
- R5: Offset 0x12 holds the initial value in bits [9:0]. A write whose low 10 bits are 0 to 3 is ignored. Bits [15:10] always read zero, and no write changes them.
- R6: A tick that arrives while the count is 1 and counting is enabled is an expiry. The count reloads from the initial value in that edge, so one period lasts exactly the initial value in ticks. If the first-timeout flag (bit 3 of offset 0x04) is clear, the expiry sets it.
- R7: An expiry while the first-timeout flag is set is a second expiry. It sets the second-timeout flag (bit 1 of offset 0x06) and raises `rst_req`, unless no-reboot is set.
- R8: With no-reboot set, a second expiry still sets the second-timeout flag but produces no `rst_req` and does not set the boot flag.
- R9: `rst_req` is high for exactly one clock. That clock is the cycle after the edge at which the second expiry is taken.
- R10: The three status flags clear when software writes 1 to their bit positions. Writing 0 leaves a flag unchanged. A flag being set in the same cycle as a clear stays set.
- R11: The boot flag (bit 2 of offset 0x06) sets whenever a reset request is issued. It is cleared only by writing 1 to it.
- R12: A second expiry on the very first tick after halt is released still produces the reset pulse. The FIRING state is entered from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-enable pulse from the external prescaler |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register word |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench goes after these corner cases:
- A reload written in the same cycle as the tick that would expire. A design that let the tick win would report a spurious first timeout.
- A first-timeout clear written in the same cycle as a new expiry. A design that let the clear win would lose the event.
- Halting at a count of 1 and then releasing halt. A state machine that only fired from COUNTING would drop that reset pulse.
- Writes of initial values 0 to 3, which must leave the old value in place.
- A second expiry under no-reboot, which must set the flag but must neither pulse nor set the boot flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_HALTED   = 2'd0,
        ST_COUNTING = 2'd1,
        ST_FIRING   = 2'd2
    } wdt_state_e;

    localparam logic [7:0] OFS_RELOAD = 8'h00;
    localparam logic [7:0] OFS_STAT1  = 8'h04;
    localparam logic [7:0] OFS_STAT2  = 8'h06;
    localparam logic [7:0] OFS_CTRL   = 8'h08;
    localparam logic [7:0] OFS_INIT   = 8'h12;

    localparam int BIT_HALT   = 11;
    localparam int BIT_NOBOOT = 0;
    localparam int BIT_FIRST  = 3;
    localparam int BIT_SECOND = 1;
    localparam int BIT_BOOT   = 2;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              set_first,
    input  logic              set_second,
    input  logic              set_boot,
    output logic [DATA_W-1:0] rdata,
    output logic              halt,
    output logic              no_reboot,
    output logic [CNT_W-1:0]  init_val,
    output logic              sts_first,
    output logic              reload_wr
);
    logic sts_second, sts_boot;
    logic wr_stat1, wr_stat2, wr_ctrl, wr_init;

    always_comb begin
        wr_stat1  = wr_en && (addr == ADDR_W'(OFS_STAT1));
        wr_stat2  = wr_en && (addr == ADDR_W'(OFS_STAT2));
        wr_ctrl   = wr_en && (addr == ADDR_W'(OFS_CTRL));
        wr_init   = wr_en && (addr == ADDR_W'(OFS_INIT));
        reload_wr = wr_en && (addr == ADDR_W'(OFS_RELOAD)) && (wdata == DATA_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt       <= 1'b1;
            no_reboot  <= 1'b1;
            init_val   <= CNT_W'(INIT_RST);
            sts_first  <= 1'b0;
            sts_second <= 1'b0;
            sts_boot   <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                halt      <= wdata[BIT_HALT];
                no_reboot <= wdata[BIT_NOBOOT];
            end
            if (wr_init && (wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN)))
                init_val <= wdata[CNT_W-1:0];
            sts_first  <= set_first  | (sts_first  & ~(wr_stat1 & wdata[BIT_FIRST]));
            sts_second <= set_second | (sts_second & ~(wr_stat2 & wdata[BIT_SECOND]));
            sts_boot   <= set_boot   | (sts_boot   & ~(wr_stat2 & wdata[BIT_BOOT]));
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(OFS_RELOAD): rdata = DATA_W'(count);
            ADDR_W'(OFS_STAT1):  rdata[BIT_FIRST] = sts_first;
            ADDR_W'(OFS_STAT2): begin
                rdata[BIT_SECOND] = sts_second;
                rdata[BIT_BOOT]   = sts_boot;
            end
            ADDR_W'(OFS_CTRL): begin
                rdata[BIT_HALT]   = halt;
                rdata[BIT_NOBOOT] = no_reboot;
            end
            ADDR_W'(OFS_INIT):   rdata = DATA_W'(init_val);
            default:             rdata = '0;
        endcase
    end

    // R5: the initial value never drops below the floor
    p_init_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CNT_W'(INIT_MIN));

    // R10: a clear with no coincident set empties the first flag
    p_w1c_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat1 && wdata[BIT_FIRST] && !set_first) |=> !sts_first);

    // R11: a boot set is visible on the next cycle
    p_boot_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_boot |=> sts_boot);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic step;

    always_comb begin
        step   = tick && !halt;
        expire = step && !reload && (count <= CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= CNT_W'(INIT_RST);
        else if (reload)
            count <= init_val;
        else if (step)
            count <= (count <= CNT_W'(1)) ? init_val : count - CNT_W'(1);
    end

    // R2: halted and not reloaded, the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count));

    // R2: a running tick above 1 takes one off
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !halt && !reload && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1));

    // R3: reload lands the initial value
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == $past(init_val));

    // R6: expiry restarts the period
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == $past(init_val));
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic expire,
    input  logic sts_first,
    input  logic no_reboot,
    output logic set_first,
    output logic set_second,
    output logic set_boot,
    output logic rst_req
);
    wdt_state_e state, state_nx;
    logic fire;

    always_comb begin
        set_first  = expire && !sts_first;
        set_second = expire && sts_first;
        fire       = set_second && !no_reboot;
        set_boot   = fire;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HALTED:   state_nx = fire ? ST_FIRING : (halt ? ST_HALTED : ST_COUNTING);
            ST_COUNTING: state_nx = fire ? ST_FIRING : (halt ? ST_HALTED : ST_COUNTING);
            ST_FIRING:   state_nx = fire ? ST_FIRING : (halt ? ST_HALTED : ST_COUNTING);
            default:     state_nx = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HALTED;
        else        state <= state_nx;
    end

    always_comb rst_req = (state == ST_FIRING);

    // R9: the request never lasts two cycles
    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7: second expiry with reboot allowed fires
    p_second_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && sts_first && !no_reboot) |=> rst_req);

    // R8: no-reboot blocks the request
    p_noreboot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && no_reboot) |=> !rst_req);
endmodule

// File: rtl/dual_expiry_wdt.sv
module dual_expiry_wdt #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    logic [CNT_W-1:0] count, init_val;
    logic halt, no_reboot, sts_first, reload_wr, expire;
    logic set_first, set_second, set_boot;

    wdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .INIT_MIN(INIT_MIN), .INIT_RST(INIT_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .count(count), .set_first(set_first), .set_second(set_second),
        .set_boot(set_boot), .rdata(rdata), .halt(halt), .no_reboot(no_reboot),
        .init_val(init_val), .sts_first(sts_first), .reload_wr(reload_wr)
    );

    wdt_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt), .reload(reload_wr),
        .init_val(init_val), .count(count), .expire(expire)
    );

    wdt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt(halt), .expire(expire),
        .sts_first(sts_first), .no_reboot(no_reboot), .set_first(set_first),
        .set_second(set_second), .set_boot(set_boot), .rst_req(rst_req)
    );
endmodule

// File: tb/tb_dual_expiry_wdt.sv
module tb_dual_expiry_wdt;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic rst_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [9:0] m_cnt, m_init;
    logic m_halt, m_nr, m_s1, m_s2, m_boot, m_rst;

    dual_expiry_wdt dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:   return {6'b0, m_cnt};
            8'h04:   return {12'b0, m_s1, 3'b0};
            8'h06:   return {13'b0, m_boot, m_s2, 1'b0};
            8'h08:   return {4'b0, m_halt, 10'b0, m_nr};
            8'h12:   return {6'b0, m_init};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R4";
            8'h04:   return "R6";
            8'h06:   return "R7";
            8'h08:   return "R2";
            8'h12:   return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic m_reset();
        m_cnt = 10'd4; m_init = 10'd4; m_halt = 1; m_nr = 1;
        m_s1 = 0; m_s2 = 0; m_boot = 0; m_rst = 0;
    endtask

    task automatic m_update(input logic t, input logic w, input logic [7:0] a, input logic [15:0] d);
        logic rl, ex, sec, fire;
        logic [9:0] nc;
        rl   = w && a == 8'h00 && d == 16'h0001;
        ex   = !m_halt && t && !rl && m_cnt <= 10'd1;
        sec  = ex && m_s1;
        fire = sec && !m_nr;
        if (rl)                nc = m_init;
        else if (!m_halt && t) nc = (m_cnt <= 10'd1) ? m_init : m_cnt - 10'd1;
        else                   nc = m_cnt;
        m_s1   = (ex && !m_s1) | (m_s1 & ~(w && a == 8'h04 && d[3]));
        m_s2   = sec | (m_s2 & ~(w && a == 8'h06 && d[1]));
        m_boot = fire | (m_boot & ~(w && a == 8'h06 && d[2]));
        if (w && a == 8'h08) begin m_halt = d[11]; m_nr = d[0]; end
        if (w && a == 8'h12 && d[9:0] >= 10'd4) m_init = d[9:0];
        m_cnt = nc;
        m_rst = fire;
    endtask

    task automatic step(input logic t, input logic w, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        tick = t; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        m_update(t, w, a, d);
        #1;
        check(rdata, m_read(a), tag_of(a));
        check({15'b0, rst_req}, {15'b0, m_rst}, "R9");
    endtask

    task automatic peek(input logic [7:0] a, input logic [15:0] exp, input string req);
        wr_en = 0; tick = 0; addr = a;
        #1;
        check(rdata, exp, req);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 8'h00, 16'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1 reset state
        peek(8'h00, 16'h0004, "R1");
        peek(8'h08, 16'h0801, "R1");
        peek(8'h12, 16'h0004, "R1");
        peek(8'h04, 16'h0000, "R1");
        peek(8'h06, 16'h0000, "R1");
        check({15'b0, rst_req}, 16'h0, "R1");
        peek(8'h30, 16'h0000, "R4");

        // R5 invalid initial values ignored, upper bits read zero
        step(0, 1, 8'h12, 16'h0002);
        peek(8'h12, 16'h0004, "R5");
        step(0, 1, 8'h12, 16'hFC05);
        peek(8'h12, 16'h0005, "R5");
        // R2 halted: ticks do nothing
        ticks(3);
        peek(8'h00, 16'h0004, "R2");
        // R3 non-matching reload value ignored, then real reload
        step(0, 1, 8'h00, 16'h0003);
        peek(8'h00, 16'h0004, "R3");
        step(0, 1, 8'h00, 16'h0001);
        peek(8'h00, 16'h0005, "R3");
        // run, reboot allowed
        step(0, 1, 8'h08, 16'h0000);
        ticks(4);
        peek(8'h00, 16'h0001, "R2");
        ticks(1);
        peek(8'h04, 16'h0008, "R6");
        peek(8'h00, 16'h0005, "R6");
        // R3 reload beats a coincident expiring tick
        ticks(4);
        step(1, 1, 8'h00, 16'h0001);
        peek(8'h06, 16'h0000, "R3");
        peek(8'h00, 16'h0005, "R3");
        // R7/R9/R11 second expiry
        ticks(4);
        step(1, 0, 8'h06, 16'h0);
        check({15'b0, rst_req}, 16'h1, "R9");
        peek(8'h06, 16'h0006, "R7");
        step(0, 0, 8'h06, 16'h0);
        check({15'b0, rst_req}, 16'h0, "R9");
        // R10 write-one-to-clear
        step(0, 1, 8'h06, 16'h0002);
        peek(8'h06, 16'h0004, "R11");
        step(0, 1, 8'h04, 16'h0000);
        peek(8'h04, 16'h0008, "R10");
        step(0, 1, 8'h04, 16'h0008);
        peek(8'h04, 16'h0000, "R10");
        step(0, 1, 8'h06, 16'h0004);
        peek(8'h06, 16'h0000, "R11");
        // R8 no-reboot: flags set, no pulse, no boot flag
        step(0, 1, 8'h08, 16'h0001);
        step(0, 1, 8'h00, 16'h0001);
        ticks(5);
        ticks(4);
        step(1, 0, 8'h06, 16'h0);
        check({15'b0, rst_req}, 16'h0, "R8");
        peek(8'h06, 16'h0002, "R8");
        step(0, 1, 8'h06, 16'h0006);
        // R10 set beats clear in the same cycle (first flag still set; clear it)
        step(0, 1, 8'h04, 16'h0008);
        ticks(4);
        step(1, 1, 8'h04, 16'h0008);
        peek(8'h04, 16'h0008, "R10");
        // R12 halt at count 1, release, expire at once
        step(0, 1, 8'h08, 16'h0000);
        ticks(4);
        step(0, 1, 8'h08, 16'h0800);
        ticks(2);
        peek(8'h00, 16'h0001, "R12");
        step(0, 1, 8'h08, 16'h0000);
        step(1, 0, 8'h06, 16'h0);
        check({15'b0, rst_req}, 16'h1, "R12");

        // constrained random phase
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic t, w;
            logic [7:0] a;
            logic [15:0] d;
            logic [2:0] sel;
            t = ($urandom % 2) == 0;
            w = ($urandom % 6) == 0;
            sel = 3'($urandom % 6);
            case (sel)
                3'd0: a = 8'h00;
                3'd1: a = 8'h04;
                3'd2: a = 8'h06;
                3'd3: a = 8'h08;
                3'd4: a = 8'h12;
                default: a = 8'h0A;
            endcase
            d = 16'($urandom);
            if (a == 8'h00 && ($urandom % 2) == 0) d = 16'h0001;
            if (a == 8'h12) d = {d[15:10], 6'b0, d[3:0]};
            if (a == 8'h08) d[11] = ($urandom % 5) == 0;
            step(t, w, a, d);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule